// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block sits between a motor controller's digital command inputs and the four gate enables of a full H-bridge built from two legs (A and B), each with a high-side and a low-side switch. It decodes direction, drive enable, slow/fast decay and synchronous-rectification requests into a target gate pattern. It then sequences each leg so that no switch turns on until its partner in the same leg has been commanded off for a programmable number of clock cycles. Switches that turn off do so without any wait.

The dead time comes from a 10-bit base count, used as is or multiplied by 32 under a long-delay select. A fault-coast request or a low `awake` input overrides every decode and drives all four gates low. A one-cycle `bridge_change` pulse marks each update of the commanded gate pattern so that a downstream drain-source monitor can restart its blanking window. All outputs are registered, and `rst` is synchronous and active high.

Top module: `hb_gate_seq`

## Requirements
- R1: With `drive_en`=1, `dir`=1 gives `hs_a`=1 and `ls_b`=1 with the other two low. `dir`=0 gives `hs_b`=1 and `ls_a`=1 with the other two low.
- R2: With `drive_en`=0, `decay_slow`=0 and `sync_rect`=0, all four gates are 0 (coast), whatever `dir` is.
- R3: With `drive_en`=0, `decay_slow`=0 and `sync_rect`=1, the opposite diagonal is driven: `hs_b`+`ls_a` for `dir`=1 and `hs_a`+`ls_b` for `dir`=0.
- R4: With `drive_en`=0, `decay_slow`=1 and `sync_rect`=1, `ls_a`=`ls_b`=1 and `hs_a`=`hs_b`=0 (brake), for either `dir`.
- R5: With `drive_en`=0, `decay_slow`=1 and `sync_rect`=0, only one low side is on: `ls_b` for `dir`=1 and `ls_a` for `dir`=0.
- R6: While `drive_en`=1, changes on `decay_slow` and `sync_rect` have no effect on any gate output.
- R7: Let D = `dt_base` when `dt_long`=0 and D = 32·`dt_base` when `dt_long`=1. When one gate of a leg falls and its partner is then commanded on, both gates of that leg stay low for exactly D cycles. The two gates of a leg are never high together.
- R8: A gate commanded off falls two clock edges after the input change is sampled, with no dead-time delay. A gate whose partner has been off for at least D cycles rises with the same two-edge latency.
- R9: While `fault_coast`=1 or `awake`=0, all four gates are 0 from the first clock edge after the condition is sampled.
- R10: `bridge_change` is high for exactly one cycle after each clock edge at which the commanded gate pattern differs from its previous value. It stays low while the pattern is unchanged.
- R11: While `rst` is high at a clock edge, all gate outputs and `bridge_change` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awake | input | 1 | 1 = bridge may be driven, 0 = sleep with all gates off |
| fault_coast | input | 1 | 1 = force all gates off |
| dir | input | 1 | Direction: 1 = current from leg A to leg B |
| drive_en | input | 1 | 1 = direct drive by `dir`; decay inputs ignored |
| decay_slow | input | 1 | 1 = slow decay, 0 = fast decay (when not driving) |
| sync_rect | input | 1 | 1 = synchronous rectification on (when not driving) |
| dt_long | input | 1 | 1 = dead time is 32 × base count |
| dt_base | input | 10 | Base dead time in clock cycles |
| hs_a | output | 1 | Leg A high-side gate enable |
| ls_a | output | 1 | Leg A low-side gate enable |
| hs_b | output | 1 | Leg B high-side gate enable |
| ls_b | output | 1 | Leg B low-side gate enable |
| bridge_change | output | 1 | One-cycle pulse on each change of commanded gates |

## Verification
The hardest case to reach from the ports is the long dead-time path. It needs a leg handover in which one gate falls and its partner waits the full 32× window, and the bench must measure that window exactly while the other leg is also switching. The stimulus first holds a direction long enough for every counter to saturate. It then reverses direction and counts the cycles in which both gates of leg A are low, with short, zero and long settings. A pseudo-random sweep with mid-run faults, sleep and reset follows, and a behavioural model compares every output on every clock.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // one bridge leg: high-side and low-side request
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_cmd_t;

  localparam int LEG_A = 0;
  localparam int LEG_B = 1;
  localparam int NUM_LEGS = 2;
endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  logic                      dir,
  input  logic                      drive_en,
  input  logic                      decay_slow,
  input  logic                      sync_rect,
  output leg_cmd_t [NUM_LEGS-1:0]   want
);
  always_comb begin
    want = '0;
    if (drive_en) begin
      // direct drive follows direction only
      if (dir) begin
        want[LEG_A].hi = 1'b1;
        want[LEG_B].lo = 1'b1;
      end else begin
        want[LEG_B].hi = 1'b1;
        want[LEG_A].lo = 1'b1;
      end
    end else begin
      unique case ({decay_slow, sync_rect})
        2'b00: want = '0;                       // coast
        2'b01: begin                            // fast decay, rectified
          if (dir) begin
            want[LEG_B].hi = 1'b1;
            want[LEG_A].lo = 1'b1;
          end else begin
            want[LEG_A].hi = 1'b1;
            want[LEG_B].lo = 1'b1;
          end
        end
        2'b11: begin                            // brake
          want[LEG_A].lo = 1'b1;
          want[LEG_B].lo = 1'b1;
        end
        default: begin                          // slow decay, diode path
          if (dir) want[LEG_B].lo = 1'b1;
          else     want[LEG_A].lo = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/hb_dt_scale.sv
module hb_dt_scale #(
  parameter int BASE_W      = 10,
  parameter int LONG_SHIFT  = 5,
  localparam int DT_W       = BASE_W + LONG_SHIFT
) (
  input  logic [BASE_W-1:0] dt_base,
  input  logic              dt_long,
  output logic [DT_W-1:0]   dt_cycles
);
  generate
    if (LONG_SHIFT > 0) begin : g_scaled
      always_comb begin
        if (dt_long) dt_cycles = {dt_base, {LONG_SHIFT{1'b0}}};
        else         dt_cycles = {{LONG_SHIFT{1'b0}}, dt_base};
      end
    end else begin : g_plain
      always_comb dt_cycles = dt_base;
    end
  endgenerate
endmodule

// File: rtl/hb_leg_gate.sv
module hb_leg_gate
  import hb_pkg::*;
#(
  parameter int DT_W = 15,
  localparam int CNT_W = DT_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            force_off,
  input  leg_cmd_t        want,
  input  logic [DT_W-1:0] dt_cycles,
  output logic            gate_hi,
  output logic            gate_lo
);
  // side 1 = high, side 0 = low
  logic [1:0]       req;
  logic             on_q  [2];
  logic [CNT_W-1:0] off_run [2];

  assign req = {want.hi, want.lo};

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int P = 1 - s;

      // cycles for which the partner has been commanded off
      always_ff @(posedge clk) begin
        if (rst)                  off_run[s] <= '0;
        else if (req[P])          off_run[s] <= '0;
        else if (off_run[s] != '1) off_run[s] <= off_run[s] + 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst || force_off) on_q[s] <= 1'b0;
        else on_q[s] <= req[s] && !req[P] && (off_run[s] >= {1'b0, dt_cycles});
      end

      p_off_prompt_r8: assert property (@(posedge clk) disable iff (rst)
        !req[s] |=> !on_q[s]);
    end
  endgenerate

  assign gate_hi = on_q[1];
  assign gate_lo = on_q[0];

  p_leg_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_pkg::*;
#(
  parameter int DT_BASE_W  = 10,
  parameter int LONG_SHIFT = 5,
  localparam int DT_W      = DT_BASE_W + LONG_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 awake,
  input  logic                 fault_coast,
  input  logic                 dir,
  input  logic                 drive_en,
  input  logic                 decay_slow,
  input  logic                 sync_rect,
  input  logic                 dt_long,
  input  logic [DT_BASE_W-1:0] dt_base,
  output logic                 hs_a,
  output logic                 ls_a,
  output logic                 hs_b,
  output logic                 ls_b,
  output logic                 bridge_change
);
  leg_cmd_t [NUM_LEGS-1:0] decoded;
  leg_cmd_t [NUM_LEGS-1:0] cmd_d;
  leg_cmd_t [NUM_LEGS-1:0] cmd_q;
  logic                    force_now;
  logic [DT_W-1:0]         dt_cycles;
  logic                    chg_q;
  logic [NUM_LEGS-1:0]     leg_hi;
  logic [NUM_LEGS-1:0]     leg_lo;

  hb_cmd_decode u_dec (
    .dir        (dir),
    .drive_en   (drive_en),
    .decay_slow (decay_slow),
    .sync_rect  (sync_rect),
    .want       (decoded)
  );

  hb_dt_scale #(.BASE_W(DT_BASE_W), .LONG_SHIFT(LONG_SHIFT)) u_dt (
    .dt_base   (dt_base),
    .dt_long   (dt_long),
    .dt_cycles (dt_cycles)
  );

  assign force_now = fault_coast || !awake;
  assign cmd_d     = force_now ? '0 : decoded;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      chg_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      chg_q <= (cmd_d != cmd_q);
    end
  end

  generate
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      hb_leg_gate #(.DT_W(DT_W)) u_leg (
        .clk       (clk),
        .rst       (rst),
        .force_off (force_now),
        .want      (cmd_q[g]),
        .dt_cycles (dt_cycles),
        .gate_hi   (leg_hi[g]),
        .gate_lo   (leg_lo[g])
      );
    end
  endgenerate

  assign hs_a          = leg_hi[LEG_A];
  assign ls_a          = leg_lo[LEG_A];
  assign hs_b          = leg_hi[LEG_B];
  assign ls_b          = leg_lo[LEG_B];
  assign bridge_change = chg_q;

  p_force_off_r9: assert property (@(posedge clk) disable iff (rst)
    (fault_coast || !awake) |=> !(hs_a || ls_a || hs_b || ls_b));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> !(hs_a || ls_a || hs_b || ls_b || bridge_change));
endmodule

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       awake = 1'b0, fault_coast = 1'b0;
  logic       dir = 1'b0, drive_en = 1'b0, decay_slow = 1'b0, sync_rect = 1'b0;
  logic       dt_long = 1'b0;
  logic [9:0] dt_base = 10'd4;
  logic       hs_a, ls_a, hs_b, ls_b, bridge_change;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  hb_gate_seq u0 (
    .clk(clk), .rst(rst), .awake(awake), .fault_coast(fault_coast),
    .dir(dir), .drive_en(drive_en), .decay_slow(decay_slow),
    .sync_rect(sync_rect), .dt_long(dt_long), .dt_base(dt_base),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
    .bridge_change(bridge_change)
  );

  // pattern bits: [3]=hs_a [2]=ls_a [1]=hs_b [0]=ls_b
  function automatic logic [3:0] ref_pattern(logic d, logic en, logic sl, logic sr);
    if (en) return d ? 4'b1001 : 4'b0110;
    if (!sl && !sr) return 4'b0000;
    if (!sl && sr)  return d ? 4'b0110 : 4'b1001;
    if (sl && sr)   return 4'b0101;
    return d ? 4'b0001 : 4'b0100;
  endfunction

  // behavioural reference: commanded pattern, off-run counts, outputs
  logic [3:0] m_cmd = '0, m_out = '0;
  logic       m_chg = 1'b0;
  int         m_run [4];
  bit         armed = 1'b0;

  always @(posedge clk) begin
    logic [3:0] nxt, nout;
    int d;
    d = dt_long ? 32 * int'(dt_base) : int'(dt_base);
    if (rst) begin
      m_cmd = '0; m_out = '0; m_chg = 1'b0;
      foreach (m_run[i]) m_run[i] = 0;
      armed = 1'b1;
    end else begin
      nxt = (fault_coast || !awake) ? 4'b0000
            : ref_pattern(dir, drive_en, decay_slow, sync_rect);
      for (int i = 0; i < 4; i++) begin
        int pi;
        pi = i ^ 1;
        nout[i] = !(fault_coast || !awake) && m_cmd[i] && !m_cmd[pi] && (m_run[i] >= d);
      end
      for (int i = 0; i < 4; i++) begin
        if (m_cmd[i ^ 1]) m_run[i] = 0;
        else if (m_run[i] < 65535) m_run[i] = m_run[i] + 1;
      end
      m_chg = (nxt != m_cmd);
      m_cmd = nxt;
      m_out = nout;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (armed) begin
      chk({cur_req, " gates"}, {hs_a, ls_a, hs_b, ls_b}, m_out);
      chk({cur_req, " R10 change"}, bridge_change, m_chg);
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      report();
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(logic d, logic en, logic sl, logic sr);
    dir = d; drive_en = en; decay_slow = sl; sync_rect = sr;
  endtask

  // measure the both-low window in leg A during a drive reversal
  task automatic gap_test(logic [9:0] b, logic lg, int exp, string r);
    int gap, guard;
    dt_base = b; dt_long = lg;
    set_ctl(1, 1, 0, 0);
    wait_n(200);
    dir = 1'b0;
    guard = 0;
    while (hs_a && guard < 10) begin @(negedge clk); guard++; end
    gap = 0;
    while (!ls_a && gap < 5000) begin gap++; @(negedge clk); end
    chk(r, gap, exp);
  endtask

  initial begin
    wait_n(4);
    chk("R11 reset outputs", {hs_a, ls_a, hs_b, ls_b, bridge_change}, 0);
    @(negedge clk); rst = 1'b0; awake = 1'b1;

    cur_req = "R1";
    set_ctl(1, 1, 0, 0); wait_n(20); chk("R1 dir=1", {hs_a, ls_a, hs_b, ls_b}, 4'b1001);
    set_ctl(0, 1, 0, 0); wait_n(20); chk("R1 dir=0", {hs_a, ls_a, hs_b, ls_b}, 4'b0110);

    cur_req = "R2";
    set_ctl(1, 0, 0, 0); wait_n(20); chk("R2 coast dir=1", {hs_a, ls_a, hs_b, ls_b}, 4'b0000);
    set_ctl(0, 0, 0, 0); wait_n(20); chk("R2 coast dir=0", {hs_a, ls_a, hs_b, ls_b}, 4'b0000);

    cur_req = "R3";
    set_ctl(1, 0, 0, 1); wait_n(20); chk("R3 dir=1", {hs_a, ls_a, hs_b, ls_b}, 4'b0110);
    set_ctl(0, 0, 0, 1); wait_n(20); chk("R3 dir=0", {hs_a, ls_a, hs_b, ls_b}, 4'b1001);

    cur_req = "R4";
    set_ctl(1, 0, 1, 1); wait_n(20); chk("R4 brake dir=1", {hs_a, ls_a, hs_b, ls_b}, 4'b0101);
    set_ctl(0, 0, 1, 1); wait_n(20); chk("R4 brake dir=0", {hs_a, ls_a, hs_b, ls_b}, 4'b0101);

    cur_req = "R5";
    set_ctl(1, 0, 1, 0); wait_n(20); chk("R5 dir=1", {hs_a, ls_a, hs_b, ls_b}, 4'b0001);
    set_ctl(0, 0, 1, 0); wait_n(20); chk("R5 dir=0", {hs_a, ls_a, hs_b, ls_b}, 4'b0100);

    cur_req = "R6";
    set_ctl(1, 1, 0, 0); wait_n(20);
    for (int k = 0; k < 4; k++) begin
      decay_slow = k[1]; sync_rect = k[0]; wait_n(10);
      chk("R6 decay inputs ignored", {hs_a, ls_a, hs_b, ls_b, bridge_change}, 5'b10010);
    end

    cur_req = "R7";
    gap_test(10'd5, 1'b0, 5,  "R7 short gap");
    gap_test(10'd0, 1'b0, 0,  "R7 zero gap");
    gap_test(10'd3, 1'b1, 96, "R7 long gap");

    cur_req = "R8";
    dt_base = 10'd4; dt_long = 1'b0;
    set_ctl(1, 1, 0, 0); wait_n(20);
    set_ctl(1, 0, 0, 0);
    @(negedge clk); chk("R8 one edge later still on", hs_a, 1);
    @(negedge clk); chk("R8 off after two edges", hs_a, 0);
    wait_n(20);
    set_ctl(1, 1, 0, 0);
    @(negedge clk); chk("R8 on not yet", hs_a, 0);
    @(negedge clk); chk("R8 on after two edges", {hs_a, ls_b}, 2'b11);

    cur_req = "R9";
    wait_n(10);
    fault_coast = 1'b1;
    @(negedge clk); chk("R9 fault forces off", {hs_a, ls_a, hs_b, ls_b}, 0);
    wait_n(10); chk("R9 fault held off", {hs_a, ls_a, hs_b, ls_b}, 0);
    fault_coast = 1'b0; wait_n(20);
    awake = 1'b0;
    @(negedge clk); chk("R9 sleep forces off", {hs_a, ls_a, hs_b, ls_b}, 0);
    awake = 1'b1; wait_n(20);

    cur_req = "R10";
    dir = 1'b0;
    @(negedge clk); chk("R10 pulse high", bridge_change, 1);
    @(negedge clk); chk("R10 pulse single", bridge_change, 0);

    cur_req = "R7 sweep";
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int t = 0; t < 3000; t++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (t % 3 == 0) begin
          set_ctl(lf[0], lf[1], lf[2], lf[3]);
          fault_coast = (lf[7:4] == 4'hF);
          awake       = (lf[11:8] != 4'h0);
          dt_long     = (lf[15:12] == 4'h7);
          dt_base     = {7'd0, lf[14:12]};
        end
        rst = (lf[15:9] == 7'h55);
        @(negedge clk);
      end
      rst = 1'b0;
    end

    cur_req = "R11";
    rst = 1'b1; wait_n(2);
    chk("R11 reset mid-run", {hs_a, ls_a, hs_b, ls_b, bridge_change}, 0);
    rst = 1'b0; wait_n(5);

    report();
    $finish;
  end
endmodule